// File: doc/BRIEF.md
# Counter accumulator line cache

This block sits inside one core and keeps a few cache lines that serve only as private counter deltas. A requester issues add-to-memory operations. Each operation carries a byte address, a lane width code and an increment. The operation returns no sum and no flags. The requester sees only a one-cycle accept. An add lands in the naturally aligned lane of a line whose accumulator state matches the lane width. The line's contents are only this core's share of the counter total, not the counter value.

When no matching line is held, an entry is claimed and zeroed, and the increment is written into its lane. The old occupant of that entry goes out on the eviction port together with its state code, so that outer logic can fold it into the shared copy or write it back. Lines that arrive through the fill port as exclusive or modified are plain data lines. An add that hits one of them changes its bytes in place, and its state does not change. A flush pulse walks all entries in index order, sends out every accumulator line and frees it, and then raises a done pulse.

Top module: `ctr_acc_cache`

## Requirements
- R1: After reset, every entry is invalid, `ev_valid` is 0 and `flush_done` is 0.
- R2: State codes on `ev_state` are: 3'b000 invalid, 3'b001 exclusive, 3'b010 modified, 3'b100/101/110/111 accumulator with 8/16/32/64-bit lanes. The low two bits equal the request width code (0=8, 1=16, 2=32, 3=64 bits).
- R3: An aligned add hits an entry whose tag equals `req_addr[31:6]` and whose state is the accumulator state of `req_width`. Address bits [5:0] select the byte of the lane's lowest byte (little endian). The lane becomes (lane + increment) mod 2^n, and no other bit of the line changes.
- R4: An aligned add that hits nothing claims the lowest-numbered invalid entry. If every entry is valid, it claims the entry at a round-robin pointer, which starts at 0 and advances by one on each such eviction. The new line is all zero except that the increment is written into the selected lane, and its state is the accumulator state of the width.
- R5: An add whose tag matches an exclusive or modified entry applies the same lane addition to that line's bytes, at any width, and the entry keeps its state.
- R6: `req_accept` is combinational, and a request is consumed in each cycle it is high. It is low when a request needs to claim a valid entry while `ev_valid` is 1 and `ev_ready` is 0.
- R7: An add whose address is not a multiple of the lane size in bytes is consumed with `req_accept` and `req_error` both high in the same cycle, and no line changes.
- R8: Every valid line that is displaced appears once on the eviction port, with its line address (low six bits zero), state and data. These outputs hold steady while `ev_valid` is 1 and `ev_ready` is 0. Lines leave in the order they were displaced.
- R9: After a `flush_start` pulse, the accumulator entries are sent out in index order and made invalid, plain entries stay, and `flush_done` pulses for one cycle when the walk ends. No request or fill is accepted from the cycle after the pulse until that done pulse.
- R10: A fill is accepted under the same entry choice and stall rule as R4 and R6. It installs `fill_data` as modified when `fill_dirty` is 1, or as exclusive otherwise. While `fill_valid` is high, no add request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Add request present |
| req_addr | input | 32 | Byte address of the counter |
| req_width | input | 2 | Lane width code, 0=8 to 3=64 bits |
| req_inc | input | 64 | Increment; low n bits used |
| req_accept | output | 1 | Request consumed this cycle |
| req_error | output | 1 | Consumed request was misaligned |
| fill_valid | input | 1 | Plain line install request |
| fill_line | input | 26 | Line address of the installed line |
| fill_data | input | 512 | Line contents |
| fill_dirty | input | 1 | Install as modified instead of exclusive |
| fill_accept | output | 1 | Fill consumed this cycle |
| flush_start | input | 1 | Begin a walk over all entries |
| flush_done | output | 1 | One-cycle pulse at the end of the walk |
| ev_valid | output | 1 | Displaced line available |
| ev_ready | input | 1 | Consumer takes the displaced line |
| ev_addr | output | 32 | Byte address of the displaced line |
| ev_state | output | 3 | State code of the displaced line |
| ev_data | output | 512 | Contents of the displaced line |

## Verification
Two kinds of cycle can coincide. In the first, a flush pulse arrives while adds and fills keep arriving. In the second, an allocation must displace a valid entry while an earlier displaced line is still waiting on the eviction port. The bench provokes both by mixing random flush pulses with a steady random stream of adds and fills, and by toggling `ev_ready` at random. A bench model predicts each cycle's accept and error and queues the expected displaced lines in order. It judges every handshake on the eviction port against that queue, which catches any eviction that is lost, duplicated or sent out of order when the two events overlap.

// File: rtl/cac_pkg.sv
package cac_pkg;
  typedef enum logic [2:0] {
    ST_INV = 3'b000,
    ST_EXC = 3'b001,
    ST_MOD = 3'b010,
    ST_A8  = 3'b100,
    ST_A16 = 3'b101,
    ST_A32 = 3'b110,
    ST_A64 = 3'b111
  } line_st_e;

  function automatic logic st_is_plain(input logic [2:0] st);
    return (st == ST_EXC) || (st == ST_MOD);
  endfunction

  function automatic logic lane_misaligned(input logic [2:0] boff, input logic [1:0] wc);
    case (wc)
      2'd0:    return 1'b0;
      2'd1:    return boff[0];
      2'd2:    return |boff[1:0];
      default: return |boff;
    endcase
  endfunction
endpackage

// File: rtl/cac_lane_add.sv
module cac_lane_add (
  input  logic [63:0] word_i,
  input  logic [2:0]  boff_i,
  input  logic [1:0]  width_i,
  input  logic [63:0] inc_i,
  output logic [63:0] word_o
);
  always_comb begin
    word_o = word_i;
    case (width_i)
      2'd0: word_o[{boff_i, 3'b000} +: 8] =
              word_i[{boff_i, 3'b000} +: 8] + inc_i[7:0];
      2'd1: word_o[{boff_i[2:1], 4'b0000} +: 16] =
              word_i[{boff_i[2:1], 4'b0000} +: 16] + inc_i[15:0];
      2'd2: word_o[{boff_i[2], 5'b00000} +: 32] =
              word_i[{boff_i[2], 5'b00000} +: 32] + inc_i[31:0];
      default: word_o = word_i + inc_i;
    endcase
  end
endmodule

// File: rtl/cac_tag_match.sv
module cac_tag_match #(
  parameter int N  = 4,
  parameter int TW = 26,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][2:0]    st_i,
  input  logic [N-1:0][TW-1:0] tag_i,
  input  logic [TW-1:0]        tag_req_i,
  input  logic [1:0]           width_i,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = (tag_i[g] == tag_req_i) &&
                      (cac_pkg::st_is_plain(st_i[g]) || (st_i[g] == {1'b1, width_i}));
  end

  always_comb begin
    hit_o = |match;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/cac_victim_pick.sv
module cac_victim_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  busy_i,
  input  logic [IW-1:0] rr_i,
  output logic [IW-1:0] victim_o,
  output logic          victim_busy_o
);
  always_comb begin
    victim_o = rr_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) victim_o = IW'(i);
    end
    victim_busy_o = &busy_i;
  end
endmodule

// File: rtl/ctr_acc_cache.sv
module ctr_acc_cache #(
  parameter int ENTRIES    = 4,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  localparam int OFFW      = $clog2(LINE_BYTES),
  localparam int TW        = AW - OFFW,
  localparam int LINE_BITS = LINE_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [AW-1:0]        req_addr,
  input  logic [1:0]           req_width,
  input  logic [63:0]          req_inc,
  output logic                 req_accept,
  output logic                 req_error,
  input  logic                 fill_valid,
  input  logic [TW-1:0]        fill_line,
  input  logic [LINE_BITS-1:0] fill_data,
  input  logic                 fill_dirty,
  output logic                 fill_accept,
  input  logic                 flush_start,
  output logic                 flush_done,
  output logic                 ev_valid,
  input  logic                 ev_ready,
  output logic [AW-1:0]        ev_addr,
  output logic [2:0]           ev_state,
  output logic [LINE_BITS-1:0] ev_data
);
  import cac_pkg::*;

  localparam int IW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int WIDX = OFFW - 3;

  line_st_e             st_q   [ENTRIES];
  logic [TW-1:0]        tag_q  [ENTRIES];
  logic [LINE_BITS-1:0] data_q [ENTRIES];
  logic [IW-1:0]        rr_q;
  logic                 fl_busy_q;
  logic [IW-1:0]        fl_idx_q;

  logic [ENTRIES-1:0][2:0]    st_pk;
  logic [ENTRIES-1:0][TW-1:0] tag_pk;
  logic [ENTRIES-1:0]         busy_pk;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      st_pk[i]   = st_q[i];
      tag_pk[i]  = tag_q[i];
      busy_pk[i] = (st_q[i] != ST_INV);
    end
  end

  logic [TW-1:0]   req_tag;
  logic [WIDX-1:0] word_sel;
  logic [2:0]      boff;
  logic            misalign;

  assign req_tag  = req_addr[AW-1:OFFW];
  assign word_sel = req_addr[OFFW-1:3];
  assign boff     = req_addr[2:0];
  assign misalign = lane_misaligned(boff, req_width);

  logic          hit;
  logic [IW-1:0] hit_idx;
  logic [IW-1:0] victim;
  logic          victim_busy;

  cac_tag_match #(.N(ENTRIES), .TW(TW)) u_match (
    .st_i(st_pk), .tag_i(tag_pk), .tag_req_i(req_tag), .width_i(req_width),
    .hit_o(hit), .idx_o(hit_idx)
  );

  cac_victim_pick #(.N(ENTRIES)) u_victim (
    .busy_i(busy_pk), .rr_i(rr_q), .victim_o(victim), .victim_busy_o(victim_busy)
  );

  logic [63:0]          word_old;
  logic [63:0]          word_new;
  logic [LINE_BITS-1:0] fresh_line;

  assign word_old = hit ? data_q[hit_idx][{word_sel, 6'b000000} +: 64] : 64'd0;

  cac_lane_add u_add (
    .word_i(word_old), .boff_i(boff), .width_i(req_width), .inc_i(req_inc),
    .word_o(word_new)
  );

  always_comb begin
    fresh_line = '0;
    fresh_line[{word_sel, 6'b000000} +: 64] = word_new;
  end

  logic slot_free, can_alloc, req_go, do_add, alloc, evict_now;
  logic fl_is_acc, fl_emit, fl_adv;

  assign slot_free   = !ev_valid || ev_ready;
  assign can_alloc   = !victim_busy || slot_free;
  assign fill_accept = fill_valid && !fl_busy_q && can_alloc;
  assign req_go      = req_valid && !fl_busy_q && !fill_valid;
  assign req_accept  = req_go && (misalign || hit || can_alloc);
  assign req_error   = req_go && misalign;
  assign do_add      = req_accept && !misalign;
  assign alloc       = fill_accept || (do_add && !hit);
  assign evict_now   = alloc && victim_busy;
  assign fl_is_acc   = st_q[fl_idx_q][2];
  assign fl_emit     = fl_busy_q && fl_is_acc && slot_free;
  assign fl_adv      = fl_busy_q && (!fl_is_acc || slot_free);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) st_q[i] <= ST_INV;
      rr_q       <= '0;
      fl_busy_q  <= 1'b0;
      fl_idx_q   <= '0;
      flush_done <= 1'b0;
      ev_valid   <= 1'b0;
    end else begin
      flush_done <= 1'b0;
      if (ev_valid && ev_ready) ev_valid <= 1'b0;

      if (evict_now) begin
        ev_valid <= 1'b1;
        ev_addr  <= {tag_q[victim], {OFFW{1'b0}}};
        ev_state <= st_q[victim];
        ev_data  <= data_q[victim];
        rr_q     <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end

      if (fill_accept) begin
        st_q[victim]   <= fill_dirty ? ST_MOD : ST_EXC;
        tag_q[victim]  <= fill_line;
        data_q[victim] <= fill_data;
      end else if (do_add) begin
        if (hit) begin
          data_q[hit_idx][{word_sel, 6'b000000} +: 64] <= word_new;
        end else begin
          st_q[victim]   <= line_st_e'({1'b1, req_width});
          tag_q[victim]  <= req_tag;
          data_q[victim] <= fresh_line;
        end
      end

      if (flush_start && !fl_busy_q) begin
        fl_busy_q <= 1'b1;
        fl_idx_q  <= '0;
      end

      if (fl_emit) begin
        ev_valid       <= 1'b1;
        ev_addr        <= {tag_q[fl_idx_q], {OFFW{1'b0}}};
        ev_state       <= st_q[fl_idx_q];
        ev_data        <= data_q[fl_idx_q];
        st_q[fl_idx_q] <= ST_INV;
      end

      if (fl_adv) begin
        if (fl_idx_q == IW'(ENTRIES - 1)) begin
          fl_busy_q  <= 1'b0;
          flush_done <= 1'b1;
        end else begin
          fl_idx_q <= fl_idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ctr_acc_cache_chk.sv
module ctr_acc_cache_chk #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  localparam int OFFW      = $clog2(LINE_BYTES),
  localparam int LINE_BITS = LINE_BYTES * 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_accept,
  input logic                 req_error,
  input logic                 fill_valid,
  input logic                 flush_done,
  input logic                 ev_valid,
  input logic                 ev_ready,
  input logic [AW-1:0]        ev_addr,
  input logic [2:0]           ev_state,
  input logic [LINE_BITS-1:0] ev_data
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ev_valid && !flush_done)); // R1
  AST_EV_STATE_LIVE: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> (ev_state != 3'b000) && (ev_state != 3'b011)); // R2
  AST_ACCEPT_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    req_accept |-> req_valid); // R6
  AST_ERR_WITH_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    req_error |-> req_accept); // R7
  AST_EV_HELD: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_addr) && $stable(ev_state) && $stable(ev_data))); // R8
  AST_EV_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> (ev_addr[OFFW-1:0] == '0)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    flush_done |=> !flush_done); // R9
  AST_FILL_BLOCKS_ADD: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> !req_accept); // R10
endmodule

bind ctr_acc_cache ctr_acc_cache_chk #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_accept(req_accept),
  .req_error(req_error), .fill_valid(fill_valid), .flush_done(flush_done),
  .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
  .ev_state(ev_state), .ev_data(ev_data)
);

// File: tb/ctr_acc_cache_test.sv
module ctr_acc_cache_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid, req_accept, req_error;
  logic [31:0]  req_addr;
  logic [1:0]   req_width;
  logic [63:0]  req_inc;
  logic         fill_valid, fill_dirty, fill_accept;
  logic [25:0]  fill_line;
  logic [511:0] fill_data;
  logic         flush_start, flush_done;
  logic         ev_valid, ev_ready;
  logic [31:0]  ev_addr;
  logic [2:0]   ev_state;
  logic [511:0] ev_data;

  always #5 clk = ~clk;

  ctr_acc_cache uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_width(req_width), .req_inc(req_inc), .req_accept(req_accept),
    .req_error(req_error), .fill_valid(fill_valid), .fill_line(fill_line),
    .fill_data(fill_data), .fill_dirty(fill_dirty), .fill_accept(fill_accept),
    .flush_start(flush_start), .flush_done(flush_done), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_addr(ev_addr), .ev_state(ev_state), .ev_data(ev_data)
  );

  int total = 0;
  int bad = 0;

  logic [2:0]   m_st  [4];
  logic [25:0]  m_tag [4];
  logic [511:0] m_dat [4];
  int           m_rr;
  bit           m_busy;
  logic [31:0]  q_addr [$];
  logic [2:0]   q_st   [$];
  logic [511:0] q_dat  [$];
  logic [2:0]   log_st  [16];
  logic [511:0] log_dat [16];
  int           pop_n;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] lane_model(input logic [63:0] w, input int boff,
                                             input int wc, input logic [63:0] inc);
    int n = 8 << wc;
    int pos = boff * 8;
    logic [63:0] mask = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
    logic [63:0] lane = ((w >> pos) + inc) & mask;
    return (w & ~(mask << pos)) | (lane << pos);
  endfunction

  task automatic push_ev(input int i);
    q_addr.push_back({m_tag[i], 6'b0});
    q_st.push_back(m_st[i]);
    q_dat.push_back(m_dat[i]);
  endtask

  task automatic step(input bit rv, input logic [31:0] ra, input logic [1:0] rw,
                      input logic [63:0] ri, input bit fv, input logic [25:0] fl_line,
                      input logic [511:0] fd, input bit fdirty, input bit er, input bit fl);
    int hit_i, vic, wsel, boff;
    bit mis, full, slot, can, e_fill, go, e_acc, e_err;
    logic [63:0] w;
    @(negedge clk);
    req_valid = rv; req_addr = ra; req_width = rw; req_inc = ri;
    fill_valid = fv; fill_line = fl_line; fill_data = fd; fill_dirty = fdirty;
    ev_ready = er; flush_start = fl;
    #1;
    if (flush_done) begin
      check(m_busy, "R9", "flush_done without walk", 512'(flush_done), 512'(0));
      m_busy = 0;
    end
    if (ev_valid && er) begin
      if (q_addr.size() == 0) begin
        check(0, "R8", "unexpected eviction", 512'(ev_addr), 512'(0));
      end else begin
        logic [31:0] ea = q_addr.pop_front();
        logic [2:0] es = q_st.pop_front();
        logic [511:0] ed = q_dat.pop_front();
        check(ev_addr == ea, "R4", "eviction address", 512'(ev_addr), 512'(ea));
        check(ev_state == es, "R2", "eviction state", 512'(ev_state), 512'(es));
        check(ev_data == ed, es[2] ? "R3" : "R5", "eviction data", ev_data, ed);
        log_st[pop_n % 16] = ev_state;
        log_dat[pop_n % 16] = ev_data;
        pop_n++;
      end
    end
    hit_i = -1;
    for (int i = 3; i >= 0; i--) begin
      if (m_st[i] != 3'b000 && m_tag[i] == ra[31:6] &&
          (m_st[i] == 3'b001 || m_st[i] == 3'b010 || m_st[i] == {1'b1, rw})) hit_i = i;
    end
    mis = (ra[2:0] & 3'((1 << rw) - 1)) != 3'd0;
    vic = m_rr; full = 1;
    for (int i = 3; i >= 0; i--) if (m_st[i] == 3'b000) begin vic = i; full = 0; end
    slot = !ev_valid || er;
    can = !full || slot;
    e_fill = fv && !m_busy && can;
    go = rv && !m_busy && !fv;
    e_acc = go && (mis || hit_i >= 0 || can);
    e_err = go && mis;
    check(fill_accept == e_fill, "R10", "fill_accept", 512'(fill_accept), 512'(e_fill));
    check(req_accept == e_acc, "R6", "req_accept", 512'(req_accept), 512'(e_acc));
    check(req_error == e_err, "R7", "req_error", 512'(req_error), 512'(e_err));
    wsel = int'(ra[5:3]); boff = int'(ra[2:0]);
    if (e_fill || (e_acc && !mis && hit_i < 0)) begin
      if (full) begin push_ev(vic); m_rr = (m_rr + 1) % 4; end
      if (e_fill) begin
        m_st[vic] = fdirty ? 3'b010 : 3'b001; m_tag[vic] = fl_line; m_dat[vic] = fd;
      end else begin
        m_st[vic] = {1'b1, rw}; m_tag[vic] = ra[31:6]; m_dat[vic] = '0;
        m_dat[vic][wsel*64 +: 64] = lane_model(64'd0, boff, int'(rw), ri);
      end
    end else if (e_acc && !mis) begin
      w = m_dat[hit_i][wsel*64 +: 64];
      m_dat[hit_i][wsel*64 +: 64] = lane_model(w, boff, int'(rw), ri);
    end
    if (fl && !m_busy) begin
      m_busy = 1;
      for (int i = 0; i < 4; i++) if (m_st[i][2]) begin push_ev(i); m_st[i] = 3'b000; end
    end
  endtask

  task automatic add(input logic [31:0] a, input logic [1:0] wc, input logic [63:0] inc);
    step(1, a, wc, inc, 0, '0, '0, 0, 1, 0);
  endtask

  task automatic rnd_step(input bit allow_fl);
    logic [1:0] wc = 2'($urandom % 4);
    logic [25:0] tag = ($urandom % 3 == 0) ? 26'(20 + $urandom % 4) : 26'(4 + $urandom % 6);
    logic [5:0] off = 6'($urandom % 64);
    logic [25:0] ftag = 26'(20 + $urandom % 4);
    bit fv = ($urandom % 8 == 0);
    logic [511:0] fd;
    logic [63:0] inc = ($urandom % 2) ? {$urandom, $urandom} : 64'($urandom % 4 + 250);
    for (int k = 0; k < 16; k++) fd[k*32 +: 32] = $urandom;
    if ($urandom % 10 != 0) off = off & ~6'((1 << wc) - 1);
    for (int i = 0; i < 4; i++) if (m_st[i] != 3'b000 && m_tag[i] == ftag) fv = 0;
    step($urandom % 4 != 0, {tag, off}, wc, inc, fv, ftag, fd, 1'($urandom),
         1'($urandom), allow_fl && !m_busy && ($urandom % 150 == 0));
  endtask

  task automatic run_flush();
    step(0, '0, 0, '0, 0, '0, '0, 0, 1'($urandom), 1);
    for (int k = 0; k < 100 && m_busy; k++) rnd_step(0);
    check(!m_busy, "R9", "walk finished", 512'(m_busy), 512'(0));
  endtask

  task automatic drain();
    for (int k = 0; k < 50 && (q_addr.size() != 0 || ev_valid); k++)
      step(0, '0, 0, '0, 0, '0, '0, 0, 1, 0);
    check(q_addr.size() == 0, "R8", "pending evictions", 512'(q_addr.size()), 512'(0));
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin m_st[i] = 3'b000; m_tag[i] = '0; m_dat[i] = '0; end
    m_rr = 0; m_busy = 0; pop_n = 0;
    rst = 1; req_valid = 0; req_addr = '0; req_width = 0; req_inc = '0;
    fill_valid = 0; fill_line = '0; fill_data = '0; fill_dirty = 0;
    ev_ready = 0; flush_start = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check(ev_valid == 0, "R1", "ev_valid after reset", 512'(ev_valid), 512'(0));
    check(flush_done == 0, "R1", "flush_done after reset", 512'(flush_done), 512'(0));
    run_flush();
    check(pop_n == 0, "R1", "evictions from empty cache", 512'(pop_n), 512'(0));

    // R3 wrap: 8-bit and 32-bit lanes overflow without touching neighbours
    add(32'h100, 2'd0, 64'hFF);
    add(32'h100, 2'd0, 64'h01);
    add(32'h208, 2'd2, 64'hFFFF_FFFF);
    add(32'h208, 2'd2, 64'h2);
    add(32'h404, 2'd3, 64'h9);       // R7 misaligned 64-bit
    pop_n = 0;
    run_flush();
    drain();
    check(log_st[0] == 3'b100 && log_dat[0] == '0, "R3", "8-bit wrap line",
          log_dat[0], '0);
    check(log_st[1] == 3'b110 && log_dat[1] == (512'd1 << 64), "R3", "32-bit wrap line",
          log_dat[1], 512'd1 << 64);
    check(pop_n == 2, "R7", "misaligned add allocated nothing", 512'(pop_n), 512'(2));

    // R5 plain line and R6 stall with eviction port held
    step(0, '0, 0, '0, 1, 26'd30, {16{32'h1111_1111}}, 0, 0, 0);
    add(32'd30 << 6 | 32'h8, 2'd2, 64'h5);
    add(32'h300, 2'd0, 64'h5);
    add(32'h300, 2'd1, 64'h7);
    add(32'h340, 2'd3, 64'h1);
    step(1, 32'h380, 2'd0, 64'h3, 0, '0, '0, 0, 0, 0);
    step(1, 32'h3C0, 2'd0, 64'h3, 0, '0, '0, 0, 0, 0);
    step(1, 32'h3C0, 2'd0, 64'h3, 0, '0, '0, 0, 0, 0);
    drain();

    for (int n = 0; n < 4000; n++) rnd_step(1);
    for (int k = 0; k < 100 && m_busy; k++) rnd_step(0);
    run_flush();
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule